// File: doc/BRIEF.md
# Transfer-Gated Looping Playback Buffer

This block stores a waveform delivered by a DMA engine and plays it back to a high-speed DAC without a break. The write side runs on the DMA clock. A word is captured only while a transfer window is open and the word is flagged valid. Each new window starts filling again from the bottom of the storage array. When a window closes after at least one capture, the top address of the newly filled region is carried across to the DAC clock through a toggle handshake.

The read side runs on the DAC clock and never stalls. Once a region has been published, it reads one address per DAC cycle and returns to address zero after the last stored word, so the captured waveform repeats for as long as needed. A later, shorter or longer capture replaces the loop length, and replay restarts from the first word. The sample word is the per-channel sample width multiplied by the channel count.

Top module: `xfer_playback_buf`

## Requirements
- R1: A word is stored only in a cycle where both `wr_xfer_req` and `wr_valid` are high. A valid word offered while `wr_xfer_req` is low changes neither the stored waveform nor the replay.
- R2: Each stored word goes to the next address. Cycles with `wr_valid` low inside a window leave no gap, so the stored words form a contiguous run starting at address 0.
- R3: The first cycle in which `wr_xfer_req` is high after a low cycle restarts the capture at address 0. A word accepted in that cycle lands at address 0.
- R4: When a window closes after N≥1 captures, the DAC side sets `rd_armed` and then outputs stored words 0..N-1 in order, one per `rd_clk` cycle, wrapping from N-1 back to 0 indefinitely.
- R5: When a later window closes after M≥1 captures, the loop length becomes M and replay restarts from address 0 with the new words.
- R6: After reset `rd_armed` is 0 and `rd_data` is all zeros until the first region is published. `rd_data` is a registered copy of the word at the current read address (one cycle from address to data).
- R7: `wr_data` and `rd_data` are SAMPLE_W×CHANNELS bits wide. Channel c occupies bits [c·SAMPLE_W +: SAMPLE_W].
- R8: A window that closes with no captured word publishes nothing, and the previous loop continues without interruption.
- R9: A window captures at most 2^ADDR_W words. Further valid words in that window are dropped, and the loop length is capped at 2^ADDR_W.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | DMA-side clock |
| wr_rst_n | input | 1 | DMA-side reset, active low, asynchronous assert |
| wr_xfer_req | input | 1 | Transfer window; high while a capture is allowed |
| wr_valid | input | 1 | Input word qualifier |
| wr_data | input | SAMPLE_W*CHANNELS | Input sample word |
| rd_clk | input | 1 | DAC-side clock |
| rd_rst_n | input | 1 | DAC-side reset, active low, asynchronous assert |
| rd_data | output | SAMPLE_W*CHANNELS | Replayed sample word, one per rd_clk cycle |
| rd_armed | output | 1 | High once a captured region is being replayed |

## Verification
The read-side properties assume that the published top address is stable whenever the toggle change is seen on the DAC side. This holds only if consecutive windows are spaced by more than a few DAC cycles, and the stimulus keeps several idle cycles between windows. The write-side properties assume that `wr_xfer_req` and `wr_valid` are synchronous to `wr_clk`, and the bench changes them only on the falling edge. Replay is compared only after the new region has settled. Words read while a new window is overwriting the array are left unchecked, because that mix of old and new data is not defined.

// File: rtl/pbuf_pkg.sv
package pbuf_pkg;
  // Number of flops in the toggle synchronizer (metastability filter depth).
  localparam int unsigned SYNC_STAGES = 3;
  // Default geometry used by the top level.
  localparam int unsigned DEF_SAMPLE_W = 16;
  localparam int unsigned DEF_CHANNELS = 2;
  localparam int unsigned DEF_ADDR_W   = 5;
endpackage

// File: rtl/pbuf_rst_sync.sv
module pbuf_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign srst_n = stage_q[1];
endmodule

// File: rtl/pbuf_wr_ctrl.sv
module pbuf_wr_ctrl #(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DW     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xfer,
  input  logic              valid,
  input  logic [DW-1:0]     data,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_waddr,
  output logic [DW-1:0]     mem_wdata,
  output logic [ADDR_W-1:0] top_hold,
  output logic              pub_tog
);
  localparam int unsigned DEPTH = 1 << ADDR_W;
  localparam logic [ADDR_W:0] DEPTH_C = (ADDR_W+1)'(DEPTH);
  localparam logic [ADDR_W:0] ONE_C   = (ADDR_W+1)'(1);

  logic              xfer_q;
  logic [ADDR_W:0]   cnt_q, cnt_nx, cnt_base, cnt_m1;
  logic              rise, fall, room, accept, pub_en;

  // next-state
  always_comb begin
    rise     = xfer & ~xfer_q;
    fall     = ~xfer & xfer_q;
    cnt_base = rise ? '0 : cnt_q;
    room     = cnt_base < DEPTH_C;
    accept   = xfer & valid & room;
    cnt_nx   = cnt_base + (accept ? ONE_C : '0);
    cnt_m1   = cnt_q - ONE_C;
    pub_en   = fall & (cnt_q != '0);
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xfer_q   <= 1'b0;
      cnt_q    <= '0;
      top_hold <= '0;
      pub_tog  <= 1'b0;
    end else begin
      xfer_q <= xfer;
      if (xfer) cnt_q <= cnt_nx;
      if (pub_en) begin
        top_hold <= cnt_m1[ADDR_W-1:0];
        pub_tog  <= ~pub_tog;
      end
    end
  end

  assign mem_we    = accept;
  assign mem_waddr = cnt_base[ADDR_W-1:0];
  assign mem_wdata = data;

  // R1: outside a window the fill count is frozen
  p_idle_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer |=> cnt_q == $past(cnt_q));
  // R2: every accepted word advances the fill by one
  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && xfer_q && valid && cnt_q < DEPTH_C) |=> cnt_q == $past(cnt_q) + ONE_C);
  // R3: a fresh window restarts the fill
  p_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && !xfer_q) |=> cnt_q <= ONE_C);
  // R9: fill never exceeds the array
  p_cap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= DEPTH_C);
  // R8: empty window publishes nothing
  p_no_empty_pub_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0) |=> pub_tog == $past(pub_tog));
endmodule

// File: rtl/pbuf_rd_ctrl.sv
module pbuf_rd_ctrl #(
  parameter int unsigned ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] top_hold,
  input  logic              pub_tog,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              armed
);
  import pbuf_pkg::*;

  logic [SYNC_STAGES-1:0] sync_q;
  logic [ADDR_W-1:0]      top_q, addr_nx;
  logic                   load, at_end;

  // next-state
  always_comb begin
    load   = sync_q[SYNC_STAGES-1] ^ sync_q[SYNC_STAGES-2];
    at_end = rd_addr == top_q;
    if (load)       addr_nx = '0;
    else if (!armed) addr_nx = rd_addr;
    else if (at_end) addr_nx = '0;
    else            addr_nx = rd_addr + ADDR_W'(1);
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= '0;
      top_q   <= '0;
      rd_addr <= '0;
      armed   <= 1'b0;
    end else begin
      sync_q  <= {sync_q[SYNC_STAGES-2:0], pub_tog};
      rd_addr <= addr_nx;
      if (load) begin
        top_q <= top_hold;
        armed <= 1'b1;
      end
    end
  end

  // R4: read address stays inside the published region
  p_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> rd_addr <= top_q);
  // R4: address walks up by one
  p_walk_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !load && rd_addr != top_q) |=> rd_addr == $past(rd_addr) + ADDR_W'(1));
  // R4: address wraps after the last stored word
  p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !load && rd_addr == top_q) |=> rd_addr == '0);
  // R5: a new region restarts replay from the first word
  p_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (rd_addr == '0 && armed));
endmodule

// File: rtl/pbuf_mem.sv
module pbuf_mem #(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DW     = 32
) (
  input  logic              wr_clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DW-1:0]     wdata,
  input  logic              rd_clk,
  input  logic              rd_rst_n,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DW-1:0]     rdata
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge wr_clk) begin
    if (we) store[waddr] <= wdata;
  end

  always_ff @(posedge rd_clk or negedge rd_rst_n) begin
    if (!rd_rst_n)  rdata <= '0;
    else if (rd_en) rdata <= store[raddr];
  end
endmodule

// File: rtl/xfer_playback_buf.sv
module xfer_playback_buf #(
  parameter int unsigned SAMPLE_W = pbuf_pkg::DEF_SAMPLE_W,
  parameter int unsigned CHANNELS = pbuf_pkg::DEF_CHANNELS,
  parameter int unsigned ADDR_W   = pbuf_pkg::DEF_ADDR_W
) (
  input  logic                         wr_clk,
  input  logic                         wr_rst_n,
  input  logic                         wr_xfer_req,
  input  logic                         wr_valid,
  input  logic [SAMPLE_W*CHANNELS-1:0] wr_data,
  input  logic                         rd_clk,
  input  logic                         rd_rst_n,
  output logic [SAMPLE_W*CHANNELS-1:0] rd_data,
  output logic                         rd_armed
);
  localparam int unsigned DW = SAMPLE_W * CHANNELS;

  logic              wr_srst_n, rd_srst_n;
  logic              mem_we, pub_tog;
  logic [ADDR_W-1:0] mem_waddr, top_hold, rd_addr;
  logic [DW-1:0]     mem_wdata;

  pbuf_rst_sync u_wr_rst (.clk(wr_clk), .arst_n(wr_rst_n), .srst_n(wr_srst_n));
  pbuf_rst_sync u_rd_rst (.clk(rd_clk), .arst_n(rd_rst_n), .srst_n(rd_srst_n));

  pbuf_wr_ctrl #(.ADDR_W(ADDR_W), .DW(DW)) u_wr (
    .clk(wr_clk), .rst_n(wr_srst_n), .xfer(wr_xfer_req), .valid(wr_valid),
    .data(wr_data), .mem_we(mem_we), .mem_waddr(mem_waddr),
    .mem_wdata(mem_wdata), .top_hold(top_hold), .pub_tog(pub_tog));

  pbuf_rd_ctrl #(.ADDR_W(ADDR_W)) u_rd (
    .clk(rd_clk), .rst_n(rd_srst_n), .top_hold(top_hold), .pub_tog(pub_tog),
    .rd_addr(rd_addr), .armed(rd_armed));

  pbuf_mem #(.ADDR_W(ADDR_W), .DW(DW)) u_mem (
    .wr_clk(wr_clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .rd_clk(rd_clk), .rd_rst_n(rd_srst_n), .rd_en(rd_armed),
    .raddr(rd_addr), .rdata(rd_data));

  // R6: output is quiet until a region is published
  p_quiet_r6: assert property (@(posedge rd_clk) disable iff (!rd_srst_n)
    !rd_armed |-> rd_data == '0);
  // R6: once armed, replay never disarms
  p_stay_armed_r6: assert property (@(posedge rd_clk) disable iff (!rd_srst_n)
    rd_armed |=> rd_armed);
endmodule

// File: tb/xfer_playback_buf_tb.sv
module xfer_playback_buf_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int RD_PERIOD  = 7;
  localparam int SW = 16;
  localparam int CH = 2;
  localparam int AW = 5;
  localparam int DW = SW * CH;
  localparam int DEPTH = 1 << AW;

  logic wr_clk = 0, rd_clk = 0;
  logic wr_rst_n, rd_rst_n, wr_xfer_req, wr_valid, rd_armed;
  logic [DW-1:0] wr_data, rd_data;

  always #(CLK_PERIOD/2) wr_clk = ~wr_clk;
  always #(RD_PERIOD/2.0) rd_clk = ~rd_clk;

  xfer_playback_buf #(.SAMPLE_W(SW), .CHANNELS(CH), .ADDR_W(AW)) dut_i (
    .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_xfer_req(wr_xfer_req),
    .wr_valid(wr_valid), .wr_data(wr_data), .rd_clk(rd_clk),
    .rd_rst_n(rd_rst_n), .rd_data(rd_data), .rd_armed(rd_armed));

  int errors = 0, checks = 0;
  bit done = 0;

  // stimulus-owned expectation
  bit    want_check = 0;
  int    exp_gen = 0, exp_base = 0, exp_len = 0;
  string exp_tag = "R4";

  // R7: channel c in bits [c*SW +: SW]
  function automatic logic [DW-1:0] word_of(int base, int i);
    logic [DW-1:0] w;
    for (int c = 0; c < CH; c++) w[c*SW +: SW] = SW'(base + i + 4096*c);
    return w;
  endfunction

  // reference model: loop of expected words, compared every DAC cycle
  int  seen_gen = 0, settle = 0, idx = 0;
  bit  locked = 0;
  always @(negedge rd_clk) begin
    if (!want_check) locked = 0;
    if (exp_gen != seen_gen) begin
      seen_gen = exp_gen; settle = 15; locked = 0;
    end else if (want_check && !locked) begin
      if (settle > 0) settle--;
      else begin
        int found = -1;
        for (int j = 0; j < exp_len; j++)
          if (rd_data == word_of(exp_base, j)) found = j;
        checks++;
        if (found < 0 || !rd_armed) begin
          errors++;
          $display("FAIL %s: rd_data=%h armed=%0b not in loop %h..%h", exp_tag,
                   rd_data, rd_armed, word_of(exp_base, 0), word_of(exp_base, exp_len-1));
        end else begin
          idx = found; locked = 1;
        end
      end
    end else if (locked) begin
      idx = (idx + 1) % exp_len;
      checks++;
      if (rd_data !== word_of(exp_base, idx) || rd_armed !== 1'b1) begin
        errors++;
        $display("FAIL %s: rd_data=%h expected %h (armed=%0b)", exp_tag,
                 rd_data, word_of(exp_base, idx), rd_armed);
      end
    end
  end

  task automatic wr_cycles(int n);
    repeat (n) @(negedge wr_clk);
  endtask

  // one window; gap inserts idle valid cycles (R2)
  task automatic window(int base, int n, bit gap);
    @(negedge wr_clk);
    wr_xfer_req = 1;
    for (int i = 0; i < n; i++) begin
      wr_valid = 1; wr_data = word_of(base, i);
      @(negedge wr_clk);
      if (gap && (i % 3 == 1)) begin
        wr_valid = 0; wr_data = '1;
        @(negedge wr_clk);
      end
    end
    wr_valid = 0;
    wr_cycles(2);
    wr_xfer_req = 0;
  endtask

  task automatic expect_loop(int base, int len, string tag);
    exp_base = base; exp_len = len; exp_tag = tag;
    want_check = 1; exp_gen++;
  endtask

  initial begin
    wr_rst_n = 0; rd_rst_n = 0;
    wr_xfer_req = 0; wr_valid = 0; wr_data = '0;
    wr_cycles(5);
    wr_rst_n = 1; rd_rst_n = 1;

    // R7: width check
    checks++;
    if ($bits(rd_data) != SW*CH || $bits(wr_data) != SW*CH) begin
      errors++;
      $display("FAIL R7: width=%0d expected %0d", $bits(rd_data), SW*CH);
    end

    // R6: reset state held with no window
    for (int k = 0; k < 8; k++) begin
      @(negedge rd_clk);
      checks++;
      if (rd_armed !== 1'b0 || rd_data !== '0) begin
        errors++;
        $display("FAIL R6: armed=%0b data=%h expected 0 / 0", rd_armed, rd_data);
      end
    end

    // R2/R3/R4: 12-word ramp with valid gaps
    window(100, 12, 1);
    expect_loop(100, 12, "R4");
    wr_cycles(60);

    // R1: valid words with no window must not disturb replay
    for (int i = 0; i < 10; i++) begin
      wr_valid = 1; wr_data = word_of(500, i);
      @(negedge wr_clk);
    end
    wr_valid = 0;
    exp_tag = "R1";
    wr_cycles(40);

    // R8: empty window keeps the old loop running
    exp_tag = "R8";
    @(negedge wr_clk);
    wr_xfer_req = 1;
    wr_cycles(5);
    wr_xfer_req = 0;
    wr_cycles(40);

    // R3/R5: shorter second window
    want_check = 0;
    wr_cycles(3);
    window(200, 5, 0);
    expect_loop(200, 5, "R5");
    wr_cycles(60);

    // R9: overlong window capped at DEPTH words
    want_check = 0;
    wr_cycles(3);
    window(300, DEPTH + 8, 0);
    expect_loop(300, DEPTH, "R9");
    wr_cycles(150);

    // R3: single word at restart address
    want_check = 0;
    wr_cycles(3);
    window(700, 1, 0);
    expect_loop(700, 1, "R3");
    wr_cycles(40);

    want_check = 0;
    wr_cycles(2);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge wr_clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not complete, expected end before timeout");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule